// File: doc/BRIEF.md
# Instruction Target Address Generator

This unit sits after instruction fetch in a small 24-bit accumulator machine. It receives up to four instruction bytes, left-aligned in a 32-bit word, and a two-bit format hint from an external opcode table. From these it decodes the instruction length, the addressing flags and the register fields. From the flags it computes a 20-bit target address using the fetch address, the base register and the index register. It also reports an addressing class and flags any flag combination that is not allowed. Opcode execution, memory access and the opcode table itself belong to other blocks.

Decoding and address arithmetic are combinational. A single output register stage presents the results one clock after the inputs, with a valid bit that follows the input valid bit.

Byte 0 of the instruction is `instr_word[31:24]`. In the memory forms the flags are held in these bits:

| Flag | Bit | Role |
|------|-----|------|
| n | 25 | addressing class |
| i | 24 | addressing class |
| x | 23 | indexing |
| b | 22 | base-relative |
| p | 21 | PC-relative |
| e | 20 | extended (4-byte) form |

The 12-bit displacement is `instr_word[19:8]`, and the 20-bit absolute field is `instr_word[19:0]`.

Top module: `tagen_top`

## Requirements
- R1: `fmt_hint` 2'b00 gives a 1-byte instruction and 2'b01 gives a 2-byte instruction. For both, `addr_class` is 0 (none), `tgt_addr` is 0 and `illegal` is 0. For the 2-byte form, `reg1`=`instr_word[23:20]` and `reg2`=`instr_word[19:16]`; in every other case both are 0.
- R2: With `fmt_hint[1]`=1, n=0 and i=0, the instruction is in the legacy form: length 3, `addr_class` 1. The target is the 15-bit field `instr_word[22:8]`, plus X when bit 23 is set.
- R3: In the new memory form with b=1 and p=0, the target is B plus the displacement, read as unsigned (0..4095).
- R4: With b=0 and p=1, the target is (`fetch_pc` + length) plus the displacement, sign-extended (-2048..2047).
- R5: With b=0 and p=0, the target is the displacement. When e=1, it is instead the 20-bit absolute field. The length is 4 when e=1 and 3 when e=0.
- R6: When x=1 and the combination is legal, the low 20 bits of X are added to the target.
- R7: `addr_class` is 2 for immediate (n=0, i=1), 3 for indirect (n=1, i=0) and 4 for simple (n=1, i=1).
- R8: x=1 together with exactly one of n and i sets `illegal`, and `tgt_addr` is then 0.
- R9: b=1 together with p=1, or e=1 together with b or p set, sets `illegal`, and `tgt_addr` is then 0.
- R10: All target sums wrap modulo 2^20. B and X contribute only their low 20 bits.
- R11: Outputs appear one clock after the inputs are sampled. `out_valid` equals the previous cycle's `in_valid`. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| in_valid | input | 1 | inputs carry an instruction |
| instr_word | input | 32 | instruction bytes, byte 0 in bits 31:24 |
| fmt_hint | input | 2 | 00 one byte, 01 two bytes, 1x memory form |
| fetch_pc | input | 20 | address of the instruction's first byte |
| base_val | input | 24 | base register B |
| index_val | input | 24 | index register X |
| out_valid | output | 1 | registered valid |
| tgt_addr | output | 20 | target address |
| reg1 | output | 4 | first register number (2-byte form) |
| reg2 | output | 4 | second register number (2-byte form) |
| instr_len | output | 3 | length in bytes, 1..4 |
| addr_class | output | 3 | 0 none, 1 legacy, 2 immediate, 3 indirect, 4 simple |
| illegal | output | 1 | forbidden flag combination |

## Verification
Indexing and a relative base can fall in the same instruction. So can a forbidden combination and a sum that would otherwise wrap past 2^20. The bench sweeps all 64 flag settings under every format hint. It uses displacements at the signed extremes and register values near 2^20, so that index, base or PC addition and the illegal checks meet in one cycle. Each output is compared against an arithmetic model that uses wide integers reduced modulo 2^20. A vector that is illegal must show a zero target, whatever its sum would have been.

// File: rtl/tagen_pkg.sv
package tagen_pkg;
  localparam int AW    = 20;
  localparam int WW    = 24;
  localparam int DW    = 12;
  localparam int LW    = 3;
  localparam int RW    = 4;
  localparam int IW    = 32;
  localparam int LEG_W = 15;

  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_LEGACY = 3'd1,
    CLS_IMM    = 3'd2,
    CLS_IND    = 3'd3,
    CLS_SIMPLE = 3'd4
  } acls_t;

  typedef enum logic [1:0] {
    BSEL_ZERO = 2'd0,
    BSEL_B    = 2'd1,
    BSEL_PC   = 2'd2,
    BSEL_BAD  = 2'd3
  } bsel_t;

  typedef struct packed {
    logic n;
    logic i;
    logic x;
    logic b;
    logic p;
    logic e;
  } flags_t;

  function automatic logic [AW-1:0] sext_disp(input logic [DW-1:0] d);
    return {{(AW-DW){d[DW-1]}}, d};
  endfunction

  function automatic logic [AW-1:0] zext_disp(input logic [DW-1:0] d);
    return {{(AW-DW){1'b0}}, d};
  endfunction

  function automatic logic [AW-1:0] wrap_add(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b);
    return a + b;
  endfunction
endpackage

// File: rtl/tagen_decode.sv
module tagen_decode
  import tagen_pkg::*;
(
  input  logic [IW-1:0]    instr_word,
  input  logic [1:0]       fmt_hint,
  output flags_t           flg,
  output logic             is_short,
  output logic             is_legacy,
  output logic             is_ext,
  output logic [LW-1:0]    length,
  output logic [DW-1:0]    disp,
  output logic [AW-1:0]    abs_field,
  output logic [LEG_W-1:0] leg_field,
  output logic [RW-1:0]    r1,
  output logic [RW-1:0]    r2,
  output acls_t            cls,
  output bsel_t            bsel,
  output logic             bad_mode,
  output logic             bad_idx
);
  localparam int FLAG_LO = IW - 12;
  logic new_form;

  assign flg       = instr_word[FLAG_LO+5:FLAG_LO];
  assign disp      = instr_word[FLAG_LO-1:FLAG_LO-DW];
  assign abs_field = instr_word[AW-1:0];
  assign leg_field = instr_word[FLAG_LO+2:FLAG_LO+3-LEG_W];

  assign is_short  = ~fmt_hint[1];
  assign is_legacy = ~is_short & ~flg.n & ~flg.i;
  assign new_form  = ~is_short & ~is_legacy;
  assign is_ext    = new_form & flg.e;

  always_comb begin
    if (is_short)    length = fmt_hint[0] ? LW'(2) : LW'(1);
    else if (is_ext) length = LW'(4);
    else             length = LW'(3);
  end

  assign r1 = (fmt_hint == 2'b01) ? instr_word[IW-9:IW-12]  : '0;
  assign r2 = (fmt_hint == 2'b01) ? instr_word[IW-13:IW-16] : '0;

  always_comb begin
    if (is_short)       cls = CLS_NONE;
    else if (is_legacy) cls = CLS_LEGACY;
    else if (!flg.n)    cls = CLS_IMM;
    else if (!flg.i)    cls = CLS_IND;
    else                cls = CLS_SIMPLE;
  end

  always_comb begin
    if (!new_form) bsel = BSEL_ZERO;
    else begin
      unique case ({flg.b, flg.p})
        2'b10:   bsel = BSEL_B;
        2'b01:   bsel = BSEL_PC;
        2'b11:   bsel = BSEL_BAD;
        default: bsel = BSEL_ZERO;
      endcase
    end
  end

  assign bad_mode = new_form & ((flg.b & flg.p) | (flg.e & (flg.b | flg.p)));
  assign bad_idx  = new_form & flg.x & (flg.n ^ flg.i);
endmodule

// File: rtl/tagen_addr.sv
module tagen_addr
  import tagen_pkg::*;
(
  input  logic             is_short,
  input  logic             is_legacy,
  input  logic             is_ext,
  input  logic             idx_flag,
  input  logic             bad,
  input  bsel_t            bsel,
  input  logic [LW-1:0]    length,
  input  logic [DW-1:0]    disp,
  input  logic [AW-1:0]    abs_field,
  input  logic [LEG_W-1:0] leg_field,
  input  logic [AW-1:0]    fetch_pc,
  input  logic [WW-1:0]    base_val,
  input  logic [WW-1:0]    index_val,
  output logic [AW-1:0]    next_pc,
  output logic [AW-1:0]    pre_idx,
  output logic [AW-1:0]    tgt
);
  logic [AW-1:0] idx_term;

  assign next_pc = wrap_add(fetch_pc, AW'(length));

  always_comb begin
    if (is_short)       pre_idx = '0;
    else if (is_legacy) pre_idx = AW'(leg_field);
    else begin
      unique case (bsel)
        BSEL_B:  pre_idx = wrap_add(base_val[AW-1:0], zext_disp(disp));
        BSEL_PC: pre_idx = wrap_add(next_pc, sext_disp(disp));
        BSEL_ZERO: pre_idx = is_ext ? abs_field : zext_disp(disp);
        default: pre_idx = '0;
      endcase
    end
  end

  assign idx_term = (idx_flag && !is_short) ? index_val[AW-1:0] : '0;
  assign tgt      = bad ? '0 : wrap_add(pre_idx, idx_term);
endmodule

// File: rtl/tagen_top.sv
module tagen_top
  import tagen_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   instr_word,
  input  logic [1:0]    fmt_hint,
  input  logic [19:0]   fetch_pc,
  input  logic [23:0]   base_val,
  input  logic [23:0]   index_val,
  output logic          out_valid,
  output logic [19:0]   tgt_addr,
  output logic [3:0]    reg1,
  output logic [3:0]    reg2,
  output logic [2:0]    instr_len,
  output logic [2:0]    addr_class,
  output logic          illegal
);
  flags_t           flg;
  logic             is_short, is_legacy, is_ext, bad_mode, bad_idx, bad_any;
  logic [LW-1:0]    length;
  logic [DW-1:0]    disp;
  logic [AW-1:0]    abs_field, next_pc, pre_idx, tgt_c;
  logic [LEG_W-1:0] leg_field;
  logic [RW-1:0]    r1, r2;
  acls_t            cls;
  bsel_t            bsel;

  tagen_decode u_dec (
    .instr_word(instr_word), .fmt_hint(fmt_hint), .flg(flg),
    .is_short(is_short), .is_legacy(is_legacy), .is_ext(is_ext),
    .length(length), .disp(disp), .abs_field(abs_field),
    .leg_field(leg_field), .r1(r1), .r2(r2), .cls(cls), .bsel(bsel),
    .bad_mode(bad_mode), .bad_idx(bad_idx)
  );

  assign bad_any = bad_mode | bad_idx;

  tagen_addr u_addr (
    .is_short(is_short), .is_legacy(is_legacy), .is_ext(is_ext),
    .idx_flag(flg.x), .bad(bad_any), .bsel(bsel), .length(length),
    .disp(disp), .abs_field(abs_field), .leg_field(leg_field),
    .fetch_pc(fetch_pc), .base_val(base_val), .index_val(index_val),
    .next_pc(next_pc), .pre_idx(pre_idx), .tgt(tgt_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      tgt_addr   <= '0;
      reg1       <= '0;
      reg2       <= '0;
      instr_len  <= '0;
      addr_class <= '0;
      illegal    <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      tgt_addr   <= tgt_c;
      reg1       <= r1;
      reg2       <= r2;
      instr_len  <= length;
      addr_class <= cls;
      illegal    <= bad_any;
    end
  end

  // Assertions
  p_valid_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_illegal_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> (tgt_addr == '0));
  p_short_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && addr_class == 3'd0) |-> (!illegal && tgt_addr == '0 && instr_len <= 3'd2));
  p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (instr_len >= 3'd1 && instr_len <= 3'd4));
  p_idx_forbid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_short && !is_legacy && flg.x && (flg.n != flg.i)) |=> illegal);
  p_legacy_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && addr_class == 3'd1) |-> (!illegal && instr_len == 3'd3));
endmodule

// File: tb/tb_tagen_top.sv
module tb_tagen_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [1:0]  fmt_hint = '0;
  logic [19:0] fetch_pc = '0;
  logic [23:0] base_val = '0;
  logic [23:0] index_val = '0;
  logic        out_valid;
  logic [19:0] tgt_addr;
  logic [3:0]  reg1, reg2;
  logic [2:0]  instr_len, addr_class;
  logic        illegal;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  tagen_top dut (.*);

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    longint exp_t, sum, d;
    int     exp_len, exp_cls, exp_r1, exp_r2, exp_bad;
    bit     nn, ii, xx, bb, pp, ee;
    string  tag;
    repeat (3) @(negedge clk);
    check("R11", "reset valid", out_valid, 0);
    check("R11", "reset target", tgt_addr, 0);
    check("R11", "reset illegal", illegal, 0);
    check("R11", "reset class", addr_class, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int rs = 0; rs < 2; rs++) begin
      for (int pat = 0; pat < 3; pat++) begin
        for (int h = 0; h < 4; h++) begin
          for (int f = 0; f < 64; f++) begin
            logic [19:0] low;
            low = (pat == 0) ? 20'h00_5A7 : (pat == 1) ? 20'hFFF_3C : 20'h800_12;
            fetch_pc  = rs ? 20'hFFFFE : 20'h01230;
            base_val  = rs ? 24'hAFFF00 : 24'h000400;
            index_val = rs ? 24'h3FFFF0 : 24'h000021;
            instr_word = {6'b101100, f[5:0], low};
            fmt_hint   = h[1:0];
            in_valid   = 1'b1;
            nn = f[5]; ii = f[4]; xx = f[3]; bb = f[2]; pp = f[1]; ee = f[0];
            exp_r1 = 0; exp_r2 = 0; exp_t = 0; exp_bad = 0; tag = "R5";
            if (h < 2) begin
              exp_len = h + 1; exp_cls = 0; tag = "R1";
              if (h == 1) begin exp_r1 = instr_word[23:20]; exp_r2 = instr_word[19:16]; end
            end else if (!nn && !ii) begin
              exp_len = 3; exp_cls = 1; tag = "R2";
              sum = instr_word[22:8];
              if (xx) sum += index_val % 1048576;
              exp_t = sum % 1048576;
            end else begin
              exp_len = ee ? 4 : 3;
              exp_cls = (nn && ii) ? 4 : (nn ? 3 : 2);
              d = instr_word[19:8];
              if ((bb && pp) || (ee && (bb || pp))) begin exp_bad = 1; tag = "R9"; end
              if (xx && (nn != ii)) begin exp_bad = 1; tag = "R8"; end
              if (bb) begin
                sum = (base_val % 1048576) + d;
                if (!exp_bad) tag = "R3";
              end else if (pp) begin
                if (d >= 2048) d -= 4096;
                sum = fetch_pc + exp_len + d + 1048576;
                if (!exp_bad) tag = "R4";
              end else
                sum = ee ? longint'(instr_word[19:0]) : d;
              if (xx) begin
                sum += index_val % 1048576;
                if (!exp_bad) tag = "R6";
              end
              if (!exp_bad && sum >= 1048576) tag = {tag, " R10"};
              exp_t = exp_bad ? 0 : sum % 1048576;
            end
            @(negedge clk);
            check(tag, "target", tgt_addr, exp_t);
            check(tag, "length", instr_len, exp_len);
            check("R7", "class", addr_class, exp_cls);
            check(exp_bad ? tag : "R1", "illegal", illegal, exp_bad);
            check("R1", "reg1", reg1, exp_r1);
            check("R1", "reg2", reg2, exp_r2);
            check("R11", "valid", out_valid, 1);
          end
        end
      end
    end

    in_valid = 1'b0;
    @(negedge clk);
    check("R11", "idle valid", out_valid, 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule